// File: doc/BRIEF.md
# Cartridge Bank Mapper with Latched Real-Time Clock

This block is the control side of a cartridge mapper for an 8-bit CPU. It decodes CPU writes by the top three address bits into four control regions. These regions hold the ROM bank number, the external-RAM enable, the selector for the RAM window and a clock latch handshake. The block also contains a real-time clock that counts seconds, minutes, hours and a 9-bit day number. The clock advances once per pulse on a 1 Hz tick input, and it can be halted. When the day number runs past its top value, a sticky overflow flag is set.

The external-RAM window is shared. The selector in region 2 routes the window either to one of the RAM banks or to one of five clock registers. A CPU write in the window region, while the window is enabled and routed to the clock, loads the running counter directly. A read of the window returns a snapshot of the clock, taken when software writes 0 and then 1 to region 3. Reads therefore stay consistent while the clock keeps running. CPU writes are single-cycle strobes with no back-pressure: the mapper takes one write in every cycle that `cpu_we` is high and never stalls the CPU.

Top module: `cart_clock_mapper`

## Requirements
- R1: A write to region 0 (`cpu_region` = 0) with data 0x0A sets `ram_en` and data 0x00 clears it. Any other data leaves it unchanged. `ram_en` is 0 after reset.
- R2: A write to region 1 loads `rom_bank` with data bits [6:0], and a value of 0 is loaded as 1. `rom_bank` is 1 after reset and is never 0.
- R3: A write to region 2 with data below 4 sets `ram_bank` to that value and clears `win_clock`. Data 0x08 to 0x0C sets `win_clock` and selects clock register (data − 8), leaving `ram_bank` unchanged. Any other data changes nothing. Reset gives `ram_bank` = 0, `win_clock` = 0 and clock register 0.
- R4: A write of 1 to region 3 while unlatched copies the running clock into the snapshot and marks the clock latched. A write of 0 while latched clears the mark. No other region-3 write changes the mark or the snapshot.
- R5: Each tick pulse advances the running clock. Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0, each wrap carrying into the next field. The 9-bit day count is held as register 3 (day bits [7:0]) and bit 0 of register 4 (day bit 8).
- R6: While bit 6 of register 4 (halt) is set, ticks leave the running clock unchanged.
- R7: A carry out of day 511 wraps the day count to 0 and sets bit 7 of register 4 (overflow). The flag stays set through later ticks until a CPU write to register 4 clears it.
- R8: `win_rdata` is 0xFF when `ram_en` is 0, and `ram_rdata` when the window is routed to RAM. When the window is routed to the clock, it is the snapshot of the selected register. Register 4 reads as {overflow, halt, 5'b0, day bit 8}.
- R9: A write in region 5 while `ram_en` and `win_clock` are set loads the selected running register. Seconds and minutes take data bits [5:0], hours take bits [4:0], register 3 takes all 8 bits, and register 4 takes bits 7, 6 and 0. A tick in the same cycle is dropped.
- R10: A latch in the same cycle as a tick captures the value from before that tick, and the tick still advances the running clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_region | input | 3 | CPU address bits [15:13] of the write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one write per cycle |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| ram_rdata | input | 8 | Data read from the external RAM |
| rom_bank | output | 7 | Selected ROM bank |
| ram_bank | output | 2 | Selected RAM bank |
| ram_en | output | 1 | RAM/clock window enabled |
| win_clock | output | 1 | Window routed to the clock registers |
| win_rdata | output | 8 | CPU read data for the RAM window |

## Verification
Two functions can fall in the same cycle: a latch and a tick. A write that loads a clock register can also coincide with a tick. The bench provokes both cases by raising `sec_tick` in the same cycle as the region-3 write of 1, or as the region-5 write. For the latch case, the snapshot must hold the pre-tick seconds, and a fresh latch must then show the advanced value. For the write case, a fresh latch must show exactly the written value.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 9;
  localparam int SEC_TOP  = 59;
  localparam int MIN_TOP  = 59;
  localparam int HOUR_TOP = 23;

  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DLO  = 3'd3,
    SEL_DHI  = 3'd4
  } rtc_sel_e;

  typedef struct packed {
    logic              ovf;
    logic              halt;
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hr;
    logic [MIN_W-1:0]  mn;
    logic [SEC_W-1:0]  sc;
  } rtc_t;
endpackage

// File: rtl/ccm_bank_regs.sv
module ccm_bank_regs
  import ccm_pkg::*;
#(
  parameter int ROM_W  = 7,
  parameter int RAMB_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        region,
  input  logic [7:0]        wdata,
  output logic [ROM_W-1:0]  rom_bank,
  output logic [RAMB_W-1:0] ram_bank,
  output logic              ram_en,
  output logic              win_clock,
  output rtc_sel_e          rtc_sel
);
  localparam int RAM_BANKS = 1 << RAMB_W;

  logic [ROM_W-1:0] rom_nxt;
  logic [7:0]       sel_off;
  logic             pick_ram, pick_clk;

  always_comb begin
    rom_nxt = wdata[ROM_W-1:0];
    if (rom_nxt == '0) rom_nxt = ROM_W'(1);
    sel_off  = wdata - 8'h08;
    pick_ram = (int'(wdata) < RAM_BANKS);
    pick_clk = (wdata >= 8'h08) && (wdata <= 8'h0C);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_bank  <= ROM_W'(1);
      ram_bank  <= '0;
      ram_en    <= 1'b0;
      win_clock <= 1'b0;
      rtc_sel   <= SEL_SEC;
    end else if (we) begin
      case (region)
        3'd0: begin
          if (wdata == 8'h0A)      ram_en <= 1'b1;
          else if (wdata == 8'h00) ram_en <= 1'b0;
        end
        3'd1: rom_bank <= rom_nxt;
        3'd2: begin
          if (pick_ram) begin
            ram_bank  <= wdata[RAMB_W-1:0];
            win_clock <= 1'b0;
          end else if (pick_clk) begin
            rtc_sel   <= rtc_sel_e'(sel_off[2:0]);
            win_clock <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R2
  rom_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_bank != '0);

  // R3
  sel_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && region == 3'd2 && wdata >= 8'(RAM_BANKS) && (wdata < 8'h08 || wdata > 8'h0C))
    |=> ($stable(ram_bank) && $stable(win_clock) && $stable(rtc_sel)));

  // R1
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && region == 3'd0 && wdata != 8'h0A && wdata != 8'h00) |=> $stable(ram_en));
endmodule

// File: rtl/ccm_rtc_counter.sv
module ccm_rtc_counter
  import ccm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sec_tick,
  input  logic     wr_en,
  input  rtc_sel_e wr_sel,
  input  logic [7:0] wdata,
  output rtc_t     cur
);
  rtc_t nxt;
  logic sc_w, mn_w, hr_w, dy_w;

  always_comb begin
    sc_w = (int'(cur.sc) >= SEC_TOP);
    mn_w = (int'(cur.mn) >= MIN_TOP);
    hr_w = (int'(cur.hr) >= HOUR_TOP);
    dy_w = &cur.day;
    nxt  = cur;
    if (wr_en) begin
      case (wr_sel)
        SEL_SEC:  nxt.sc = wdata[SEC_W-1:0];
        SEL_MIN:  nxt.mn = wdata[MIN_W-1:0];
        SEL_HOUR: nxt.hr = wdata[HOUR_W-1:0];
        SEL_DLO:  nxt.day[7:0] = wdata;
        SEL_DHI: begin
          nxt.day[8] = wdata[0];
          nxt.halt   = wdata[6];
          nxt.ovf    = wdata[7];
        end
        default: ;
      endcase
    end else if (sec_tick && !cur.halt) begin
      nxt.sc = sc_w ? '0 : cur.sc + SEC_W'(1);
      if (sc_w) begin
        nxt.mn = mn_w ? '0 : cur.mn + MIN_W'(1);
        if (mn_w) begin
          nxt.hr = hr_w ? '0 : cur.hr + HOUR_W'(1);
          if (hr_w) begin
            nxt.day = cur.day + DAY_W'(1);
            if (dy_w) nxt.ovf = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  // R6
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.halt && !wr_en) |=> $stable(cur));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.ovf && !(wr_en && wr_sel == SEL_DHI)) |=> cur.ovf);

  // R5
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_en && !cur.halt && int'(cur.sc) < SEC_TOP)
    |=> cur.sc == $past(cur.sc) + SEC_W'(1));

  // R9
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_SEC) |=> cur.sc == $past(wdata[SEC_W-1:0]));
endmodule

// File: rtl/ccm_rtc_latch.sv
module ccm_rtc_latch
  import ccm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_latch,
  input  logic [7:0] wdata,
  input  rtc_t       cur,
  output rtc_t       snap,
  output logic       latched
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap    <= '0;
      latched <= 1'b0;
    end else if (we_latch) begin
      if (latched && wdata == 8'h00) begin
        latched <= 1'b0;
      end else if (!latched && wdata == 8'h01) begin
        snap    <= cur;
        latched <= 1'b1;
      end
    end
  end

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_latch |=> $stable(latched));

  // R4
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> $stable(snap));

  // R10
  snap_pre_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_latch && !latched && wdata == 8'h01) |=> snap == $past(cur));
endmodule

// File: rtl/cart_clock_mapper.sv
module cart_clock_mapper
  import ccm_pkg::*;
#(
  parameter int ROM_W  = 7,
  parameter int RAMB_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cpu_region,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  input  logic              sec_tick,
  input  logic [7:0]        ram_rdata,
  output logic [ROM_W-1:0]  rom_bank,
  output logic [RAMB_W-1:0] ram_bank,
  output logic              ram_en,
  output logic              win_clock,
  output logic [7:0]        win_rdata
);
  localparam logic [2:0] REG_LATCH = 3'd3;
  localparam logic [2:0] REG_WIN   = 3'd5;

  rtc_sel_e rtc_sel;
  rtc_t     cur, snap;
  logic     latched;
  logic     clk_wr, latch_wr;

  assign clk_wr   = cpu_we && cpu_region == REG_WIN && ram_en && win_clock;
  assign latch_wr = cpu_we && cpu_region == REG_LATCH;

  ccm_bank_regs #(.ROM_W(ROM_W), .RAMB_W(RAMB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cpu_we), .region(cpu_region), .wdata(cpu_wdata),
    .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_en(ram_en),
    .win_clock(win_clock), .rtc_sel(rtc_sel)
  );

  ccm_rtc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(clk_wr),
    .wr_sel(rtc_sel), .wdata(cpu_wdata), .cur(cur)
  );

  ccm_rtc_latch u_latch (
    .clk(clk), .rst_n(rst_n), .we_latch(latch_wr), .wdata(cpu_wdata),
    .cur(cur), .snap(snap), .latched(latched)
  );

  always_comb begin
    if (!ram_en) begin
      win_rdata = 8'hFF;
    end else if (!win_clock) begin
      win_rdata = ram_rdata;
    end else begin
      case (rtc_sel)
        SEL_SEC:  win_rdata = 8'(snap.sc);
        SEL_MIN:  win_rdata = 8'(snap.mn);
        SEL_HOUR: win_rdata = 8'(snap.hr);
        SEL_DLO:  win_rdata = snap.day[7:0];
        SEL_DHI:  win_rdata = {snap.ovf, snap.halt, 5'b0, snap.day[8]};
        default:  win_rdata = 8'hFF;
      endcase
    end
  end

  // R8
  closed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_en |-> win_rdata == 8'hFF);

  // R8
  ram_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !win_clock) |-> win_rdata == ram_rdata);
endmodule

// File: tb/cart_clock_mapper_tb.sv
module cart_clock_mapper_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cpu_region = '0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_we = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] ram_rdata = 8'h3C;
  logic [6:0] rom_bank;
  logic [1:0] ram_bank;
  logic       ram_en, win_clock;
  logic [7:0] win_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  cart_clock_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_region(cpu_region), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .sec_tick(sec_tick), .ram_rdata(ram_rdata),
    .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_en(ram_en),
    .win_clock(win_clock), .win_rdata(win_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] r, input logic [7:0] d);
    @(negedge clk);
    cpu_region = r; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic relatch();
    wr(3'd3, 8'h00);
    wr(3'd3, 8'h01);
  endtask

  task automatic rd(input int sel, output int v);
    wr(3'd2, 8'(8 + sel));
    v = int'(win_rdata);
  endtask

  task automatic setreg(input int sel, input logic [7:0] d);
    wr(3'd2, 8'(8 + sel));
    wr(3'd5, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    longint t0, tot;
    do_reset();
    // reset state: R1 R2 R3 R8
    check("R1 reset ram_en", ram_en, 0);
    check("R2 reset rom_bank", rom_bank, 1);
    check("R3 reset ram_bank", ram_bank, 0);
    check("R3 reset win_clock", win_clock, 0);
    check("R8 closed window", win_rdata, 8'hFF);

    // R1 sweep from both starting states
    for (int d = 0; d < 256; d++) begin
      wr(3'd0, 8'h00);
      wr(3'd0, 8'(d));
      check("R1 from off", ram_en, (d == 8'h0A) ? 1 : 0);
      wr(3'd0, 8'h0A);
      wr(3'd0, 8'(d));
      check("R1 from on", ram_en, (d == 0) ? 0 : 1);
    end

    // R2 sweep
    for (int d = 0; d < 256; d++) begin
      wr(3'd1, 8'(d));
      check("R2 rom bank", rom_bank, ((d & 8'h7F) == 0) ? 1 : (d & 8'h7F));
    end

    // R3 sweep and R8 RAM routing
    wr(3'd0, 8'h0A);
    for (int d = 0; d < 256; d++) begin
      wr(3'd2, 8'h01);
      wr(3'd2, 8'(d));
      check("R3 bank", ram_bank, (d < 4) ? d : 1);
      check("R3 route", win_clock, (d >= 8 && d <= 12) ? 1 : 0);
    end
    wr(3'd2, 8'h02);
    ram_rdata = 8'hA5;
    @(negedge clk);
    check("R8 ram route", win_rdata, 8'hA5);

    // clock after reset: zeros
    do_reset();
    wr(3'd0, 8'h0A);
    relatch();
    for (int s = 0; s < 5; s++) begin
      rd(s, v);
      check("R8 reset clock", v, 0);
    end

    // R5 R7 sweep across a day wrap with overflow
    setreg(4, 8'h01);
    setreg(3, 8'hFF);
    setreg(2, 8'd23);
    setreg(1, 8'd50);
    setreg(0, 8'd0);
    t0 = 64'd511 * 86400 + 23 * 3600 + 50 * 60;
    for (int n = 1; n <= 1200; n++) begin
      tick_once();
      if (n % 50 == 0) begin
        tot = t0 + n;
        relatch();
        rd(0, v); check("R5 seconds", v, int'(tot % 60));
        rd(1, v); check("R5 minutes", v, int'((tot / 60) % 60));
        rd(2, v); check("R5 hours", v, int'((tot / 3600) % 24));
        rd(3, v); check("R5 day low", v, int'((tot / 86400) % 256));
        rd(4, v); check("R7 reg4", v,
                        (((tot / 86400) >= 512) ? 8'h80 : 0) | int'(((tot / 86400) / 256) % 2));
      end
    end
    // R7 clear by write
    setreg(4, 8'h00);
    relatch();
    rd(4, v); check("R7 cleared", v, 0);

    // R6 halt and R8 unused bits
    setreg(0, 8'd5);
    setreg(4, 8'h40);
    repeat (3) tick_once();
    relatch();
    rd(0, v); check("R6 halted seconds", v, 5);
    setreg(4, 8'hFF);
    relatch();
    rd(4, v); check("R8 reg4 mask", v, 8'hC1);
    setreg(4, 8'h00);

    // R10 latch coincides with tick
    setreg(0, 8'd10);
    wr(3'd3, 8'h00);
    @(negedge clk);
    cpu_region = 3'd3; cpu_wdata = 8'h01; cpu_we = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0; sec_tick = 1'b0;
    rd(0, v); check("R10 pre-tick snapshot", v, 10);
    relatch();
    rd(0, v); check("R10 tick kept", v, 11);

    // R9 write coincides with tick
    @(negedge clk);
    cpu_region = 3'd5; cpu_wdata = 8'd30; cpu_we = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0; sec_tick = 1'b0;
    relatch();
    rd(0, v); check("R9 write beats tick", v, 30);

    // R4 handshake: 1 while latched and other values do nothing
    tick_once();
    wr(3'd3, 8'h01);
    rd(0, v); check("R4 no relatch on 1", v, 30);
    wr(3'd3, 8'h02);
    wr(3'd3, 8'h01);
    rd(0, v); check("R4 other value ignored", v, 30);
    wr(3'd3, 8'h00);
    tick_once();
    wr(3'd3, 8'h00);
    rd(0, v); check("R4 unlatch keeps snapshot", v, 30);
    wr(3'd3, 8'h01);
    rd(0, v); check("R4 relatch", v, 32);

    // R9 no clock write when routed to RAM
    wr(3'd2, 8'h00);
    wr(3'd5, 8'd7);
    relatch();
    rd(0, v); check("R9 ram route no write", v, 32);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule